// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns one parallel character at a time into an asynchronous serial frame on a single transmit line. A producer offers a byte with a valid/ready handshake. The block then sends a start bit, the data bits least-significant first, an optional parity bit and a stop period. Bit timing comes from a one-cycle strobe generated by an external baud generator. Every bit lasts a fixed number of strobes, 16 by default.

An 8-bit line-control byte sets the frame format. It selects the word length, the stop length, whether parity is sent, and the parity rule (odd, even or a constant). The format fields are captured when a character is accepted, so one frame always keeps a single format. The break field is different: it acts live and pulls the line low for as long as it is set. The sequencer keeps running underneath a break.

Top module: `uart_frame_tx`

## Requirements
- R1: With no frame in progress the line rests at 1. A frame opens with a 0 start bit, and each start, data and parity bit lasts TICKS_PER_BIT (16) baud strobes. Strobes that arrive while idle change nothing.
- R2: Control bits [1:0] set the word length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Data goes out least-significant bit first, and data bits above the word length are never sent.
- R3: Control bit 2 = 0 gives a stop period of 16 strobes at level 1. Bit 2 = 1 gives 24 strobes with a 5-bit word and 32 strobes with 6, 7 or 8 bits.
- R4: Control bit 3 = 1 inserts one parity bit directly after the last data bit. Bit 3 = 0 sends no parity bit. Parity covers only the bits inside the word length.
- R5: With parity on and bit 5 = 0, bit 4 = 0 makes the count of ones in data plus parity odd, and bit 4 = 1 makes it even.
- R6: With parity on and bit 5 = 1, the parity bit is fixed: it is 1 when bit 4 = 0 and 0 when bit 4 = 1.
- R7: While control bit 6 is 1, the line is 0 at once, whether the block is idle or in a frame. The sequencer does not pause. Once the bit clears, the line shows the bit the sequencer is sending at that moment.
- R8: After reset the line is 1, busy is 0 and ready is 1. Control bit 7 does not change the frame.
- R9: The format fields (bits 0 to 5) are taken when a character is accepted. Changing them during a frame leaves that frame unchanged.
- R10: Ready is high only while idle, and a character is accepted on a clock edge where valid and ready are both high. Busy is high from the cycle after acceptance until the edge that consumes the last stop strobe, and it falls only on a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-cycle baud strobe |
| in_valid | input | 1 | Character offered |
| in_data | input | 8 | Character to send |
| in_ready | output | 1 | Block can take a character |
| line_ctl | input | 8 | Line-control byte |
| tx | output | 1 | Serial transmit line |
| busy | output | 1 | Frame in progress |

## Verification
The start bit reaches the line in the same cycle that busy rises, which is the cycle after the accepting edge, because the line is decoded from registered sequencer state. After that the line level may change only on the clock edge that consumes a strobe, and the break field acts on the line with no delay at all. For every strobe the bench queues the level the line should show, and the monitor checks one entry on each clock half-cycle in which a strobe is present and busy is high. Each check happens at the falling edge, before the rising edge that consumes that strobe. If busy falls early, entries are left in the queue; if it falls late, the monitor tries to take an entry from an empty queue. Both cases are caught as a wrong frame length.

// File: rtl/uart_tx_pkg.sv
// Package: shared types and line-control field positions for the UART
// frame transmitter. Assumes a byte-wide line-control word.
package uart_tx_pkg;

    localparam int LC_WLEN_LO = 0;  // word length field, 2 bits
    localparam int LC_STOP    = 2;  // extended stop length
    localparam int LC_PAR_EN  = 3;  // parity insertion
    localparam int LC_PAR_SEL = 4;  // even / constant-zero select
    localparam int LC_PAR_FIX = 5;  // constant parity
    localparam int LC_BRK     = 6;  // live break override

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PAR,
        PH_STOP
    } tx_phase_e;

    // Frame format captured at character acceptance.
    typedef struct packed {
        logic [3:0] nbits;      // data bits, 5..8
        logic [2:0] stop_half;  // stop length in half-bit units: 2, 3 or 4
        logic       par_en;     // parity bit present
        logic       par_bit;    // value of the parity bit for this character
    } frame_cfg_t;

endpackage

// File: rtl/uart_tx_ctl_decode.sv
// Module: turns the line-control format fields and the offered character
// into a frame descriptor, including the parity bit value.
// Assumes DATA_W >= 8 so every word length fits.
module uart_tx_ctl_decode
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [5:0]        fmt,
    input  logic [DATA_W-1:0] data,
    output frame_cfg_t        cfg
);

    logic [3:0]        nbits;
    logic [DATA_W-1:0] kept;
    logic              ones_odd;

    // Word length: 5 plus the two-bit field.
    assign nbits = 4'd5 + {2'b00, fmt[LC_WLEN_LO+1:LC_WLEN_LO]};

    // Keep only the bits that fall inside the word length.
    for (genvar i = 0; i < DATA_W; i++) begin : g_keep
        assign kept[i] = data[i] & (nbits > 4'(i));
    end

    assign ones_odd = ^kept;

    // Assemble the descriptor: stop length and parity rule.
    always_comb begin
        cfg.nbits  = nbits;
        cfg.par_en = fmt[LC_PAR_EN];
        if (!fmt[LC_STOP]) begin
            cfg.stop_half = 3'd2;
        end else if (nbits == 4'd5) begin
            cfg.stop_half = 3'd3;
        end else begin
            cfg.stop_half = 3'd4;
        end
        if (fmt[LC_PAR_FIX]) begin
            cfg.par_bit = ~fmt[LC_PAR_SEL];
        end else if (fmt[LC_PAR_SEL]) begin
            cfg.par_bit = ones_odd;
        end else begin
            cfg.par_bit = ~ones_odd;
        end
    end

endmodule

// File: rtl/uart_tx_bit_timer.sv
// Module: counts baud strobes inside the current bit and flags the strobe
// that ends it. Assumes limit >= 1 and restart only while not running.
module uart_tx_bit_timer #(
    parameter int TICKS_PER_BIT = 16,
    localparam int CW = $clog2(2*TICKS_PER_BIT+1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          run,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          bit_end
);

    logic [CW-1:0] cnt;

    // Last strobe of the current bit.
    assign bit_end = run && tick && (cnt == limit - 1'b1);

    // Strobe counter, cleared at frame start and at each bit boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (run && tick) begin
            cnt <= bit_end ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/uart_tx_sequencer.sv
// Module: frame phase machine and data shifter. Captures character and
// descriptor on accept, steps one bit per bit_end, drives the unbroken
// line level. Assumes accept only in the idle phase.
module uart_tx_sequencer
    import uart_tx_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = 16,
    localparam int CW   = $clog2(2*TICKS_PER_BIT+1),
    localparam int HALF = TICKS_PER_BIT / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [DATA_W-1:0] data_in,
    input  frame_cfg_t        cfg_in,
    input  logic              bit_end,
    output logic              line_bit,
    output logic              busy,
    output logic [CW-1:0]     limit
);

    tx_phase_e         phase;
    logic [DATA_W-1:0] shreg;
    logic [3:0]        idx;
    frame_cfg_t        cfg_q;

    // Length of the current bit in strobes.
    assign limit = (phase == PH_STOP) ? CW'(cfg_q.stop_half) * CW'(HALF)
                                      : CW'(TICKS_PER_BIT);

    assign busy = (phase != PH_IDLE);

    // Phase transitions, data shifting and capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            shreg <= '0;
            idx   <= '0;
            cfg_q <= '0;
        end else if (accept) begin
            phase <= PH_START;
            shreg <= data_in;
            idx   <= '0;
            cfg_q <= cfg_in;
        end else if (bit_end) begin
            unique case (phase)
                PH_START: begin
                    phase <= PH_DATA;
                    idx   <= '0;
                end
                PH_DATA: begin
                    shreg <= shreg >> 1;
                    if (idx == cfg_q.nbits - 4'd1) begin
                        phase <= cfg_q.par_en ? PH_PAR : PH_STOP;
                    end else begin
                        idx <= idx + 4'd1;
                    end
                end
                PH_PAR:  phase <= PH_STOP;
                PH_STOP: phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Line level for the current phase.
    always_comb begin
        unique case (phase)
            PH_START: line_bit = 1'b0;
            PH_DATA:  line_bit = shreg[0];
            PH_PAR:   line_bit = cfg_q.par_bit;
            default:  line_bit = 1'b1;
        endcase
    end

endmodule

// File: rtl/uart_frame_tx.sv
// Module: top of the UART frame transmitter. Handshake, decode, timer and
// sequencer, with the live break override on the output line.
// Assumes baud_tick is a one-cycle strobe from an external divider.
module uart_frame_tx
    import uart_tx_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = 16,
    localparam int CW = $clog2(2*TICKS_PER_BIT+1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    input  logic [7:0]        line_ctl,
    output logic              tx,
    output logic              busy
);

    frame_cfg_t    cfg;
    logic          accept;
    logic          bit_end;
    logic          line_bit;
    logic [CW-1:0] limit;
    logic          ctl_unused;

    // Bit 7 carries no framing meaning here.
    assign ctl_unused = line_ctl[7];

    // Handshake: take a character only while idle.
    assign in_ready = ~busy;
    assign accept   = in_valid & in_ready;

    // Break forces the line low, independent of the sequencer.
    assign tx = line_ctl[LC_BRK] ? 1'b0 : line_bit;

    uart_tx_ctl_decode #(.DATA_W(DATA_W)) u_decode (
        .fmt  (line_ctl[5:0]),
        .data (in_data),
        .cfg  (cfg)
    );

    uart_tx_bit_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (accept),
        .run     (busy),
        .tick    (baud_tick),
        .limit   (limit),
        .bit_end (bit_end)
    );

    uart_tx_sequencer #(
        .DATA_W        (DATA_W),
        .TICKS_PER_BIT (TICKS_PER_BIT)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .data_in  (in_data),
        .cfg_in   (cfg),
        .bit_end  (bit_end),
        .line_bit (line_bit),
        .busy     (busy),
        .limit    (limit)
    );

endmodule

// File: rtl/uart_frame_tx_chk.sv
// Module: property checker for uart_frame_tx, attached by bind.
module uart_frame_tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       baud_tick,
    input logic       in_valid,
    input logic       in_ready,
    input logic [7:0] line_ctl,
    input logic       tx,
    input logic       busy
);

    // Break holds the line low.
    p_break_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        line_ctl[6] |-> !tx);

    // Idle line rests high without break.
    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !line_ctl[6]) |-> tx);

    // The first busy cycle shows the start bit.
    p_start_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && !line_ctl[6]) |-> !tx);

    // An accepted character makes the block busy next cycle.
    p_accept_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> busy);

    // Busy ends only on a strobe.
    p_busy_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !baud_tick) |=> busy);

    // Idle persists without an accept.
    p_idle_stays_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(in_valid && in_ready)) |=> !busy);

    // No ready while a frame is in flight.
    p_no_ready_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !in_ready);

endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .line_ctl  (line_ctl),
    .tx        (tx),
    .busy      (busy)
);

// File: tb/uart_frame_tx_bench.sv
// Scoreboard bench: the driver queues the expected line level for each
// strobe, and the monitor compares at falling edges where a strobe is present.
module uart_frame_tx_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic [7:0] line_ctl = 8'h00;
    logic       tx;
    logic       busy;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    logic  exp_q[$];
    int    tdiv = 0;

    always #2.5 clk = ~clk;

    uart_frame_tx u_uart_frame_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .line_ctl  (line_ctl),
        .tx        (tx),
        .busy      (busy)
    );

    // Baud strobe every third cycle, changed just after the rising edge.
    always @(posedge clk) begin
        #1;
        tdiv      = (tdiv == 2) ? 0 : tdiv + 1;
        baud_tick = (tdiv == 0);
    end

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: one queued level per strobe seen while busy.
    always @(negedge clk) begin
        if (rst_n && baud_tick && busy) begin
            check("R10", {31'd0, in_ready}, 32'd0, "ready while busy");
            if (exp_q.size() == 0) begin
                check("R10", 32'd1, 32'd0, "busy past frame end");
            end else begin
                logic e;
                e = exp_q.pop_front();
                if (line_ctl[6]) e = 1'b0;
                check(cur_req, {31'd0, tx}, {31'd0, e}, "line level");
            end
        end
    end

    // Build the expected per-strobe levels of one frame.
    task automatic push_frame(input logic [7:0] d, input logic [7:0] c);
        int   wl;
        int   stp;
        logic p;
        logic x;
        wl = 5 + int'(c[1:0]);
        x  = 1'b0;
        for (int i = 0; i < 16; i++) exp_q.push_back(1'b0);
        for (int b = 0; b < wl; b++) begin
            x = x ^ d[b];
            for (int i = 0; i < 16; i++) exp_q.push_back(d[b]);
        end
        if (c[3]) begin
            if (c[5]) p = ~c[4];
            else      p = c[4] ? x : ~x;
            for (int i = 0; i < 16; i++) exp_q.push_back(p);
        end
        stp = !c[2] ? 16 : (wl == 5 ? 24 : 32);
        for (int i = 0; i < stp; i++) exp_q.push_back(1'b1);
    endtask

    // Driver: offer a character and follow the frame. Optional format change
    // at strobe alt_at, and a break from brk_on to brk_off (0 = unused).
    task automatic send(input string req, input logic [7:0] d, input logic [7:0] c,
                        input int alt_at, input logic [7:0] alt_c,
                        input int brk_on, input int brk_off);
        int tk;
        int act;
        tk = 0;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        push_frame(d, c);
        cur_req = req;
        @(posedge clk); #1;
        in_valid = 1'b1;
        in_data  = d;
        line_ctl = c;
        @(posedge clk); #1;
        in_valid = 1'b0;
        forever begin
            @(negedge clk);
            if (!busy) break;
            act = 0;
            if (baud_tick) begin
                tk++;
                if (tk == alt_at)  act = 1;
                if (tk == brk_on)  act = 2;
                if (tk == brk_off) act = 3;
            end
            @(posedge clk); #1;
            if (act == 1) line_ctl = {line_ctl[7:6], alt_c[5:0]};
            if (act == 2) line_ctl[6] = 1'b1;
            if (act == 3) line_ctl[6] = 1'b0;
        end
        check("R10", exp_q.size(), 32'd0, "levels left at busy fall");
        exp_q.delete();
        line_ctl[6] = 1'b0;
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        check("R8", {31'd0, tx}, 32'd1, "tx after reset");
        check("R8", {31'd0, busy}, 32'd0, "busy after reset");
        check("R8", {31'd0, in_ready}, 32'd1, "ready after reset");

        // R1 strobes while idle change nothing
        repeat (40) @(negedge clk);
        check("R1", {31'd0, tx}, 32'd1, "idle line");
        check("R1", {31'd0, busy}, 32'd0, "idle busy");

        // R7 break while idle
        @(posedge clk); #1 line_ctl = 8'h40;
        @(negedge clk);
        check("R7", {31'd0, tx}, 32'd0, "idle break");
        repeat (10) @(negedge clk);
        check("R7", {31'd0, busy}, 32'd0, "break does not start frame");
        @(posedge clk); #1 line_ctl = 8'h00;
        @(negedge clk);
        check("R7", {31'd0, tx}, 32'd1, "break released");

        send("R2", 8'hA5, 8'h03, 0, 8'h00, 0, 0);   // 8N1
        send("R2", 8'hE6, 8'h00, 0, 8'h00, 0, 0);   // 5-bit, upper bits dropped
        send("R3", 8'h5A, 8'h04, 0, 8'h00, 0, 0);   // 5-bit, 1.5 stop
        send("R3", 8'h3C, 8'h06, 0, 8'h00, 0, 0);   // 7-bit, 2 stop
        send("R5", 8'h37, 8'h1B, 0, 8'h00, 0, 0);   // even
        send("R5", 8'h37, 8'h0B, 0, 8'h00, 0, 0);   // odd
        send("R4", 8'hC1, 8'h19, 0, 8'h00, 0, 0);   // 6-bit even, parity masked
        send("R6", 8'h00, 8'h2B, 0, 8'h00, 0, 0);   // forced 1
        send("R6", 8'hFF, 8'h3B, 0, 8'h00, 0, 0);   // forced 0
        send("R8", 8'h96, 8'h83, 0, 8'h00, 0, 0);   // bit 7 set
        send("R9", 8'h71, 8'h03, 20, 8'h3C, 0, 0);  // format changed mid-frame
        send("R7", 8'hF0, 8'h03, 0, 8'h00, 30, 60); // break mid-frame
        send("R1", 8'h01, 8'h01, 0, 8'h00, 0, 0);   // back to back
        send("R1", 8'h80, 8'h0F, 0, 8'h00, 0, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule